// File: doc/BRIEF.md
# 2D Descriptor DMA Address Generator

This block generates the address sequence for one DMA channel that moves a two-dimensional window. A window is a set of lines of equal byte length. Each line starts a fixed stride after the start of the previous line. Software programs a descriptor with three register writes: the start address, then the line and byte counts, then the stride. The block holds at most two descriptors. It walks the head descriptor by offering one burst at a time and advances when the bus accepts that burst.

Bursts going to the bus from memory (transmit direction) have a selectable size. Bursts written to memory (receive direction) are always the base size. A line whose remaining bytes are fewer than the burst size ends with a shorter burst. Status outputs show the burst being offered, the current line and the current byte position. The block also produces single-cycle end-of-line, end-of-window and programming-error events, plus a FIFO occupancy watermark.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `active`, `pending`, `burst_req`, the three event pulses and `watermark` are 0, and `burst_addr`, `cur_line` and `cur_byte` are 0.
- R2: Select code 0 loads the start address and code 1 loads the counts (lines in bits 31:16, bytes per line in bits 15:0). Writing select code 2 (stride, bits 15:0) commits the descriptor. If the queue was empty, `burst_req` is 1 in the next cycle with `burst_addr` equal to the start address. The three low bits of the address and of the stride are treated as zero.
- R3: Within a line, each burst has length min(remaining bytes, burst size), and the next burst address is the previous one plus that length. The last burst of a line may therefore be shorter.
- R4: Each new line starts at the previous line's start address plus the stride. `cur_line` counts lines from 0, and `cur_byte` is the byte offset within the line of the burst being offered.
- R5: In transmit (`dir_rx`=0), `rd_size_code` 00 selects 64 bytes, 01 selects 128 and 11 selects 256. The code 10 falls back to 64. In receive (`dir_rx`=1) bursts are always 64 bytes.
- R6: `eol_pulse` is 1 for one cycle, the cycle after the edge that accepts the last burst of a line. For the last line of the window, `eow_pulse` is 1 in that same cycle.
- R7: Two descriptors can be queued, and `pending` is 1 exactly while both slots are full. When the head descriptor completes and a second one is queued, the second one's first burst is offered in the very next cycle.
- R8: Any descriptor write while `pending` is 1 is ignored and makes `prog_err` 1 in the next cycle.
- R9: A commit with a byte count or line count of 0 is dropped: no descriptor is queued, and `prog_err` is 1 in the next cycle.
- R10: `active` stays 1 while a descriptor is queued. It falls, together with `eow_pulse`, when the last queued descriptor completes.
- R11: While `burst_ack` is 0, the offered burst address, length and position do not change.
- R12: In receive, `watermark` is loaded with `fifo_blocks` when a descriptor starts from idle, then holds the largest value seen while active. In transmit it copies `fifo_blocks` every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr_en | input | 1 | Descriptor word write strobe |
| desc_wr_sel | input | 2 | Word select: 0 address, 1 counts, 2 stride (commit) |
| desc_wr_data | input | 32 | Descriptor word data |
| dir_rx | input | 1 | 1 = receive (write bursts), 0 = transmit (read bursts) |
| rd_size_code | input | 2 | Transmit burst size code |
| fifo_blocks | input | 4 | Current FIFO block occupancy |
| burst_ack | input | 1 | Bus accepts the offered burst this cycle |
| burst_req | output | 1 | A burst is offered |
| burst_addr | output | 32 | Address of the offered burst (current address) |
| burst_len | output | 9 | Byte length of the offered burst |
| cur_line | output | 16 | Current line number |
| cur_byte | output | 16 | Current byte offset within the line |
| pending | output | 1 | Both queue slots full; writes refused |
| active | output | 1 | A descriptor is being transferred |
| eol_pulse | output | 1 | End-of-line event |
| eow_pulse | output | 1 | End-of-window event |
| prog_err | output | 1 | Programming-error event |
| watermark | output | 4 | FIFO occupancy watermark |

## Verification
The assertions assume that `desc_wr_sel` never carries code 3 together with a write strobe, and that `dir_rx` and `rd_size_code` stay constant while a descriptor is active, so that the length bound holds for the whole walk. The bench changes direction and size code only while the block is idle, and it writes only select codes 0 to 2. The stall property also assumes the bus does not accept a burst that is not offered. The bench drives `burst_ack` as a level, and the block ignores it while idle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int AW         = 32;
  localparam int CW         = 16;
  localparam int LW         = 9;
  localparam int UNIT_BYTES = 64;
  localparam int ALIGN_BITS = 3;

  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_COUNTS = 2'd1,
    SEL_STRIDE = 2'd2
  } word_sel_e;

  typedef struct packed {
    logic [AW-1:0] start;
    logic [CW-1:0] lines;
    logic [CW-1:0] bytes;
    logic [CW-1:0] stride;
  } desc_t;

  // burst size in bytes for a direction and size code
  function automatic logic [LW-1:0] burst_bytes(input logic [1:0] code, input logic rx);
    if (rx) return LW'(UNIT_BYTES);
    case (code)
      2'b01:   return LW'(2 * UNIT_BYTES);
      2'b11:   return LW'(4 * UNIT_BYTES);
      default: return LW'(UNIT_BYTES);
    endcase
  endfunction

  // length of the next burst given bytes left in the line
  function automatic logic [LW-1:0] chunk_len(input logic [CW-1:0] remaining,
                                              input logic [LW-1:0] cap);
    if (remaining < CW'(cap)) return LW'(remaining);
    return cap;
  endfunction

  function automatic logic [AW-1:0] align_addr(input logic [AW-1:0] a);
    return {a[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  function automatic logic [CW-1:0] align_stride(input logic [CW-1:0] s);
    return {s[CW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/dma2d_desc_queue.sv
module dma2d_desc_queue
  import dma2d_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          pop,
  output desc_t         head,
  output logic          head_valid,
  output logic          full,
  output logic          reject,
  output logic          load_evt,
  output logic          from_idle,
  output desc_t         load_desc
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    stg_start;
  logic [CW-1:0]    stg_lines;
  logic [CW-1:0]    stg_bytes;
  desc_t            slot [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_after_pop;
  logic             wr_ok;
  logic             stride_wr;
  logic             zero_count;
  logic             commit_ok;
  desc_t            incoming;

  always_comb begin
    full          = (cnt == CNT_W'(DEPTH));
    wr_ok         = wr_en && !full;
    stride_wr     = wr_ok && (wr_sel == SEL_STRIDE);
    zero_count    = (stg_lines == '0) || (stg_bytes == '0);
    commit_ok     = stride_wr && !zero_count;
    reject        = (wr_en && full) || (stride_wr && zero_count);
    cnt_after_pop = cnt - CNT_W'(pop);
    incoming      = '{start: stg_start, lines: stg_lines, bytes: stg_bytes,
                      stride: align_stride(wr_data[CW-1:0])};
    from_idle     = commit_ok && (cnt == '0);
    load_evt      = (commit_ok && (cnt_after_pop == '0)) || (pop && (cnt > CNT_W'(1)));
    load_desc     = (pop && (cnt > CNT_W'(1))) ? slot[1] : incoming;
    head          = slot[0];
    head_valid    = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_start <= '0;
      stg_lines <= '0;
      stg_bytes <= '0;
      cnt       <= '0;
    end else begin
      if (wr_ok && (wr_sel == SEL_START))  stg_start <= align_addr(wr_data);
      if (wr_ok && (wr_sel == SEL_COUNTS)) begin
        stg_lines <= wr_data[2*CW-1:CW];
        stg_bytes <= wr_data[CW-1:0];
      end
      cnt <= cnt_after_pop + CNT_W'(commit_ok);
    end
  end

  // slot storage: shift on pop, append at the first free slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else begin
        if (pop) begin
          if (i < DEPTH - 1) slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
        end
        if (commit_ok && (cnt_after_pop == CNT_W'(i))) slot[i] <= incoming;
      end
    end
  end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  desc_t         head,
  input  logic          head_valid,
  input  logic          load_evt,
  input  desc_t         load_desc,
  input  logic [LW-1:0] cap,
  input  logic          burst_ack,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] cur_len,
  output logic [CW-1:0] cur_line,
  output logic [CW-1:0] cur_byte,
  output logic          pop,
  output logic          eol_evt,
  output logic          eow_evt
);
  logic [AW-1:0] line_base;
  logic [CW-1:0] remaining;
  logic          line_done;
  logic          window_done;
  logic          fire;
  logic [AW-1:0] next_line_base;
  logic          unused_start;

  assign unused_start = ^head.start;

  always_comb begin
    remaining      = head.bytes - cur_byte;
    cur_len        = chunk_len(remaining, cap);
    line_done      = (remaining == CW'(cur_len));
    window_done    = (cur_line == head.lines - CW'(1));
    fire           = head_valid && burst_ack;
    eol_evt        = fire && line_done;
    eow_evt        = eol_evt && window_done;
    pop            = eow_evt;
    next_line_base = line_base + AW'(head.stride);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_base <= '0;
      cur_addr  <= '0;
      cur_byte  <= '0;
      cur_line  <= '0;
    end else if (load_evt) begin
      line_base <= load_desc.start;
      cur_addr  <= load_desc.start;
      cur_byte  <= '0;
      cur_line  <= '0;
    end else if (fire) begin
      if (!line_done) begin
        cur_addr <= cur_addr + AW'(cur_len);
        cur_byte <= cur_byte + CW'(cur_len);
      end else if (!window_done) begin
        line_base <= next_line_base;
        cur_addr  <= next_line_base;
        cur_byte  <= '0;
        cur_line  <= cur_line + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma2d_watermark.sv
module dma2d_watermark #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx,
  input  logic         active,
  input  logic         start,
  input  logic [W-1:0] blocks,
  output logic [W-1:0] level
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        level <= '0;
    else if (!rx || start)             level <= blocks;
    else if (active && blocks > level) level <= blocks;
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int WM_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            desc_wr_en,
  input  logic [1:0]      desc_wr_sel,
  input  logic [AW-1:0]   desc_wr_data,
  input  logic            dir_rx,
  input  logic [1:0]      rd_size_code,
  input  logic [WM_W-1:0] fifo_blocks,
  input  logic            burst_ack,
  output logic            burst_req,
  output logic [AW-1:0]   burst_addr,
  output logic [LW-1:0]   burst_len,
  output logic [CW-1:0]   cur_line,
  output logic [CW-1:0]   cur_byte,
  output logic            pending,
  output logic            active,
  output logic            eol_pulse,
  output logic            eow_pulse,
  output logic            prog_err,
  output logic [WM_W-1:0] watermark
);
  desc_t         head;
  desc_t         load_desc;
  logic          head_valid;
  logic          reject;
  logic          load_evt;
  logic          from_idle;
  logic          pop;
  logic          eol_evt;
  logic          eow_evt;
  logic [LW-1:0] cap;

  assign cap = burst_bytes(rd_size_code, dir_rx);

  dma2d_desc_queue #(.DEPTH(2)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (desc_wr_en),
    .wr_sel    (desc_wr_sel),
    .wr_data   (desc_wr_data),
    .pop       (pop),
    .head      (head),
    .head_valid(head_valid),
    .full      (pending),
    .reject    (reject),
    .load_evt  (load_evt),
    .from_idle (from_idle),
    .load_desc (load_desc)
  );

  dma2d_walker u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .head      (head),
    .head_valid(head_valid),
    .load_evt  (load_evt),
    .load_desc (load_desc),
    .cap       (cap),
    .burst_ack (burst_ack),
    .cur_addr  (burst_addr),
    .cur_len   (burst_len),
    .cur_line  (cur_line),
    .cur_byte  (cur_byte),
    .pop       (pop),
    .eol_evt   (eol_evt),
    .eow_evt   (eow_evt)
  );

  dma2d_watermark #(.W(WM_W)) u_wm (
    .clk   (clk),
    .rst_n (rst_n),
    .rx    (dir_rx),
    .active(head_valid),
    .start (from_idle),
    .blocks(fifo_blocks),
    .level (watermark)
  );

  assign burst_req = head_valid;
  assign active    = head_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eol_pulse <= 1'b0;
      eow_pulse <= 1'b0;
      prog_err  <= 1'b0;
    end else begin
      eol_pulse <= eol_evt;
      eow_pulse <= eow_evt;
      prog_err  <= reject;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        desc_wr_en,
  input logic        dir_rx,
  input logic [1:0]  rd_size_code,
  input logic        burst_ack,
  input logic        burst_req,
  input logic [31:0] burst_addr,
  input logic [8:0]  burst_len,
  input logic [15:0] cur_byte,
  input logic        pending,
  input logic        active,
  input logic        eol_pulse,
  input logic        eow_pulse,
  input logic        prog_err,
  input logic [3:0]  watermark
);
  logic [8:0] size_limit;
  always_comb begin
    if (dir_rx)                     size_limit = 9'd64;
    else if (rd_size_code == 2'b01) size_limit = 9'd128;
    else if (rd_size_code == 2'b11) size_limit = 9'd256;
    else                            size_limit = 9'd64;
  end

  assert_first_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && cur_byte == 16'd0) |-> (burst_addr[2:0] == 3'b000));

  assert_len_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (burst_len != 9'd0 && burst_len <= size_limit));

  assert_window_end_closes_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eow_pulse |-> eol_pulse);

  assert_pending_implies_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> active);

  assert_busy_write_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && pending) |=> prog_err);

  assert_idle_after_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> eow_pulse);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && !burst_ack) |=> $stable(burst_addr));

  assert_wm_monotonic_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && dir_rx && $past(dir_rx)) |-> (watermark >= $past(watermark)));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .desc_wr_en  (desc_wr_en),
  .dir_rx      (dir_rx),
  .rd_size_code(rd_size_code),
  .burst_ack   (burst_ack),
  .burst_req   (burst_req),
  .burst_addr  (burst_addr),
  .burst_len   (burst_len),
  .cur_byte    (cur_byte),
  .pending     (pending),
  .active      (active),
  .eol_pulse   (eol_pulse),
  .eow_pulse   (eow_pulse),
  .prog_err    (prog_err),
  .watermark   (watermark)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_wr_en = 1'b0;
  logic [1:0]  desc_wr_sel = 2'd0;
  logic [31:0] desc_wr_data = '0;
  logic        dir_rx = 1'b0;
  logic [1:0]  rd_size_code = 2'b00;
  logic [3:0]  fifo_blocks = '0;
  logic        burst_ack = 1'b0;
  logic        burst_req;
  logic [31:0] burst_addr;
  logic [8:0]  burst_len;
  logic [15:0] cur_line;
  logic [15:0] cur_byte;
  logic        pending;
  logic        active;
  logic        eol_pulse;
  logic        eow_pulse;
  logic        prog_err;
  logic [3:0]  watermark;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .desc_wr_en(desc_wr_en), .desc_wr_sel(desc_wr_sel),
    .desc_wr_data(desc_wr_data), .dir_rx(dir_rx), .rd_size_code(rd_size_code),
    .fifo_blocks(fifo_blocks), .burst_ack(burst_ack), .burst_req(burst_req),
    .burst_addr(burst_addr), .burst_len(burst_len), .cur_line(cur_line),
    .cur_byte(cur_byte), .pending(pending), .active(active), .eol_pulse(eol_pulse),
    .eow_pulse(eow_pulse), .prog_err(prog_err), .watermark(watermark)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic write_word(input logic [1:0] sel, input logic [31:0] data);
    desc_wr_en   = 1'b1;
    desc_wr_sel  = sel;
    desc_wr_data = data;
    @(negedge clk);
    desc_wr_en   = 1'b0;
  endtask

  task automatic load(input logic [31:0] start, input int bc, input int lc, input int off);
    write_word(2'd0, start);
    write_word(2'd1, {16'(lc), 16'(bc)});
    write_word(2'd2, 32'(off));
  endtask

  // walks an expected window; burst_ack must already be 1
  task automatic run_desc(input logic [31:0] start, input int bc, input int lc,
                          input int off, input int bs, input string tag);
    for (int l = 0; l < lc; l++) begin
      int b = 0;
      while (b < bc) begin
        int len = (bc - b < bs) ? bc - b : bs;
        logic last = (b + len >= bc);
        chk(32'(burst_req), 1, {tag, " R3 burst offered"});
        chk(burst_addr, start + 32'(l * off) + 32'(b), {tag, " R3/R4 address"});
        chk(32'(burst_len), 32'(len), {tag, " R3/R5 length"});
        chk(32'(cur_line), 32'(l), {tag, " R4 line"});
        chk(32'(cur_byte), 32'(b), {tag, " R4 byte"});
        @(negedge clk);
        chk(32'(eol_pulse), 32'(last), {tag, " R6 end of line"});
        chk(32'(eow_pulse), 32'(last && (l == lc - 1)), {tag, " R6 end of window"});
        b += len;
      end
    end
  endtask

  task automatic t_reset();
    chk(32'(active), 0, "R1 active");
    chk(32'(pending), 0, "R1 pending");
    chk(32'(burst_req), 0, "R1 burst_req");
    chk(32'(eol_pulse | eow_pulse | prog_err), 0, "R1 pulses");
    chk(burst_addr, 0, "R1 address");
    chk(32'({cur_line, cur_byte}), 0, "R1 position");
    chk(32'(watermark), 0, "R1 watermark");
  endtask

  task automatic t_basic_walk();
    dir_rx = 1'b0; rd_size_code = 2'b00; burst_ack = 1'b1;
    load(32'h1000, 150, 3, 32'h200);
    chk(32'(active), 1, "R2 active after commit");
    run_desc(32'h1000, 150, 3, 32'h200, 64, "walk64");
    chk(32'(active), 0, "R10 idle after window");
  endtask

  task automatic t_sizes();
    burst_ack = 1'b1; dir_rx = 1'b0;
    rd_size_code = 2'b11;
    load(32'h10000, 600, 2, 32'h400);
    run_desc(32'h10000, 600, 2, 32'h400, 256, "R5 size256");
    rd_size_code = 2'b01;
    load(32'h20000, 200, 1, 0);
    run_desc(32'h20000, 200, 1, 0, 128, "R5 size128");
    rd_size_code = 2'b10;
    load(32'h30000, 100, 1, 0);
    run_desc(32'h30000, 100, 1, 0, 64, "R5 code10");
    rd_size_code = 2'b11; dir_rx = 1'b1;
    load(32'h40000, 130, 1, 0);
    run_desc(32'h40000, 130, 1, 0, 64, "R5 rx fixed");
    dir_rx = 1'b0; rd_size_code = 2'b00;
  endtask

  task automatic t_alignment();
    burst_ack = 1'b1;
    load(32'h3005, 16, 2, 32'h10F);
    run_desc(32'h3000, 16, 2, 32'h108, 64, "R2 align");
  endtask

  task automatic t_queue();
    burst_ack = 1'b0;
    load(32'h4000, 100, 2, 32'h80);
    chk(32'(pending), 0, "R7 one slot not pending");
    load(32'h8000, 64, 2, 32'h40);
    chk(32'(pending), 1, "R7 two slots pending");
    chk(burst_addr, 32'h4000, "R11 stalled address");
    chk(32'(cur_byte), 0, "R11 stalled byte");
    write_word(2'd0, 32'hDEAD0000);
    chk(32'(prog_err), 1, "R8 busy write flagged");
    @(negedge clk);
    chk(32'(prog_err), 0, "R8 single pulse");
    chk(burst_addr, 32'h4000, "R11 still stalled");
    burst_ack = 1'b1;
    run_desc(32'h4000, 100, 2, 32'h80, 64, "R7 first");
    chk(32'(active), 1, "R7 no gap active");
    chk(32'(pending), 0, "R7 pending released");
    run_desc(32'h8000, 64, 2, 32'h40, 64, "R8 second unchanged");
    chk(32'(active), 0, "R10 idle after last");
  endtask

  task automatic t_zero_count();
    burst_ack = 1'b1;
    load(32'h2000, 0, 3, 8);
    chk(32'(prog_err), 1, "R9 zero bytes flagged");
    chk(32'(active), 0, "R9 zero bytes dropped");
    load(32'h2000, 8, 0, 8);
    chk(32'(prog_err), 1, "R9 zero lines flagged");
    chk(32'(active), 0, "R9 zero lines dropped");
  endtask

  task automatic t_watermark();
    dir_rx = 1'b1; burst_ack = 1'b0; fifo_blocks = 4'd0;
    load(32'h50000, 8, 1, 0);
    chk(32'(watermark), 0, "R12 cleared at start");
    fifo_blocks = 4'd3; @(negedge clk);
    chk(32'(watermark), 3, "R12 rises to 3");
    fifo_blocks = 4'd9; @(negedge clk);
    chk(32'(watermark), 9, "R12 rises to 9");
    fifo_blocks = 4'd5; @(negedge clk);
    chk(32'(watermark), 9, "R12 holds maximum");
    fifo_blocks = 4'd0; burst_ack = 1'b1;
    run_desc(32'h50000, 8, 1, 0, 64, "R12 rx drain");
    dir_rx = 1'b0;
    fifo_blocks = 4'd6; @(negedge clk);
    chk(32'(watermark), 6, "R12 tx follows");
    fifo_blocks = 4'd2; @(negedge clk);
    chk(32'(watermark), 2, "R12 tx follows down");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_walk();
        t_sizes();
        t_alignment();
        t_queue();
        t_zero_count();
        t_watermark();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule